// File: doc/BRIEF.md
# Serial Watchdog Timeout Selector

This block is a serial target in SPI mode 0 that holds the two-bit timeout selection of a watchdog timer. A host sends one-byte instructions, MSB first, over SCK and SI while holding the active-low select `cs_n` low. One instruction arms a change-enable latch and another disarms it. A third carries a data byte that replaces the selection. A fourth shifts the selection back out on SO. The selection is written to a store that is nonvolatile in a real system. Here that store is modelled as a fixed busy period after each accepted write. During that period the block refuses changes and answers reads with a busy level instead of data.

All serial inputs are sampled by the block clock, which must run several times faster than SCK. Edges on SCK and `cs_n` are found by comparing each input with its value one clock earlier. Instructions that change state act on the clock that first sees `cs_n` high at the end of the frame. They act only if the number of SCK rising edges in the frame is exactly the count the instruction needs. The data byte has this layout: bits 7:5 reserved, bit 4 the upper selection bit, bit 3 the lower selection bit, bits 2:0 reserved.

Top module: `wdc_spi_ctrl`

## Requirements
- R1: After reset `wd_sel` equals `SEL_RESET` (default 00), `so_oe` is low and the change-enable latch is clear.
- R2: With the latch set and no write busy, a frame of exactly 16 SCK rising edges whose first byte is 01h and whose data byte has all reserved bits zero sets `wd_sel` to data bits {4,3}. The change is visible on the first clock edge that samples `cs_n` high.
- R3: A write frame sent while the latch is clear leaves `wd_sel` unchanged.
- R4: An 8-edge frame with opcode 04h clears the latch, so a later write frame is ignored.
- R5: A write frame that ends after 15 or after 17 SCK rising edges is ignored and leaves the latch as it was.
- R6: Opcode 05h is followed on SO by the byte 000,sel[1],sel[0],000, MSB first. Each bit changes only after a falling edge of SCK, starting with the fall that follows the 8th rising edge.
- R7: For `BUSY_CYCLES` clocks after an accepted write, a read returns all ones (FFh). Write instructions and latch instructions are ignored during that time.
- R8: The latch clears when the busy period ends, so a second write without a new 06h is ignored.
- R9: A write frame with any reserved data bit set to one is rejected. It starts no busy period and leaves the latch set.
- R10: `so_oe` is low whenever `cs_n` is high.
- R11: After reset, no instruction is taken until `cs_n` has gone from high to low. Frames clocked with `cs_n` held low since reset have no effect.
- R12: The 06h opcode sets the latch only when the frame ends after exactly 8 SCK rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low target select; a falling edge opens a frame |
| sck | input | 1 | Serial clock, idle low; rises sample SI, falls advance SO |
| si | input | 1 | Serial data in, MSB first |
| so | output | 1 | Serial data out, valid while `so_oe` is high |
| so_oe | output | 1 | Output enable for SO, high only inside an opened frame |
| wd_sel | output | 2 | Stored watchdog timeout selection |

## Verification
A `cs_n` rise driven between clock edges changes `wd_sel` on the very next rising edge. The edge-detect register and the control register meet on that same clock. The bench updates its behavioural model at the moment it raises `cs_n`, and compares `wd_sel` and `so_oe` one nanosecond after every rising edge. SO moves one clock after the falling SCK edge that causes the move. The bench holds each SCK level for four clocks and reads SO just before the next rise, so the value has settled. Reads that are meant to see the busy level, or to see the end of it, are placed hundreds of clocks away from the end of the busy window. No check depends on the exact clock on which the busy period ends.

// File: rtl/wdc_pkg.sv
package wdc_pkg;
  localparam int OP_BITS    = 8;
  localparam int FRAME_BITS = 2 * OP_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);
  localparam int SEL_W      = 2;
  localparam int SEL_LSB    = 3;

  localparam logic [OP_BITS-1:0] OP_ARM    = 8'h06;
  localparam logic [OP_BITS-1:0] OP_DISARM = 8'h04;
  localparam logic [OP_BITS-1:0] OP_WRITE  = 8'h01;
  localparam logic [OP_BITS-1:0] OP_READ   = 8'h05;

  localparam logic [OP_BITS-1:0] SEL_MASK  = OP_BITS'(((1 << SEL_W) - 1) << SEL_LSB);
  localparam logic [OP_BITS-1:0] RSV_MASK  = ~SEL_MASK;
endpackage

// File: rtl/wdc_spi_rx.sv
module wdc_spi_rx
  import wdc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  sck,
  input  logic                  si,
  output logic                  active,
  output logic                  frame_start,
  output logic                  frame_end,
  output logic                  sck_fall,
  output logic                  op_ready,
  output logic [OP_BITS-1:0]    op_byte,
  output logic [CNT_W-1:0]      bit_cnt,
  output logic [FRAME_BITS-1:0] word
);
  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  logic                  sck_q, cs_q;
  logic                  active_nx;
  logic [CNT_W-1:0]      cnt_nx;
  logic [FRAME_BITS-1:0] word_nx;
  logic                  sck_rise;

  always_comb begin
    frame_start = cs_q & ~cs_n;
    frame_end   = ~cs_q & cs_n & active;
    sck_rise    = active & ~cs_n & sck & ~sck_q;
    sck_fall    = active & ~cs_n & ~sck & sck_q;
    op_byte     = {word[OP_BITS-2:0], si};
    op_ready    = sck_rise && (bit_cnt == CNT_W'(OP_BITS - 1));

    active_nx = active;
    if (frame_start)  active_nx = 1'b1;
    else if (cs_n)    active_nx = 1'b0;

    cnt_nx  = bit_cnt;
    word_nx = word;
    if (frame_start) begin
      cnt_nx = '0;
    end else if (sck_rise) begin
      word_nx = {word[FRAME_BITS-2:0], si};
      if (bit_cnt != CNT_SAT) cnt_nx = bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      cs_q    <= 1'b0;
      active  <= 1'b0;
      bit_cnt <= '0;
      word    <= '0;
    end else begin
      sck_q   <= sck;
      cs_q    <= cs_n;
      active  <= active_nx;
      bit_cnt <= cnt_nx;
      word    <= word_nx;
    end
  end

  // R11: no bit is counted while no frame has been opened
  a_r11_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !cs_n && !frame_start) |=> $stable(bit_cnt));
endmodule

// File: rtl/wdc_ctrl.sv
module wdc_ctrl
  import wdc_pkg::*;
#(
  parameter int               BUSY_CYCLES = 2_000_000,
  parameter logic [SEL_W-1:0] SEL_RESET   = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_end,
  input  logic [CNT_W-1:0]      bit_cnt,
  input  logic [FRAME_BITS-1:0] word,
  output logic [SEL_W-1:0]      wd_sel,
  output logic                  busy
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  logic [BW-1:0]    busy_cnt, busy_nx;
  logic             wel, wel_nx;
  logic [SEL_W-1:0] sel_nx;
  logic [OP_BITS-1:0] op_hi, data_lo;
  logic             lat_cmd, wr_cmd;

  always_comb begin
    busy    = (busy_cnt != '0);
    op_hi   = word[FRAME_BITS-1:OP_BITS];
    data_lo = word[OP_BITS-1:0];
    lat_cmd = frame_end & ~busy & (bit_cnt == CNT_W'(OP_BITS));
    wr_cmd  = frame_end & ~busy & (bit_cnt == CNT_W'(FRAME_BITS)) &
              (op_hi == OP_WRITE) & wel & ((data_lo & RSV_MASK) == '0);

    wel_nx = wel;
    if (lat_cmd && data_lo == OP_ARM)         wel_nx = 1'b1;
    else if (lat_cmd && data_lo == OP_DISARM) wel_nx = 1'b0;
    else if (busy_cnt == BW'(1))              wel_nx = 1'b0;

    sel_nx  = wr_cmd ? data_lo[SEL_LSB +: SEL_W] : wd_sel;

    busy_nx = busy_cnt;
    if (wr_cmd)    busy_nx = BW'(BUSY_CYCLES);
    else if (busy) busy_nx = busy_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel      <= 1'b0;
      wd_sel   <= SEL_RESET;
      busy_cnt <= '0;
    end else begin
      wel      <= wel_nx;
      wd_sel   <= sel_nx;
      busy_cnt <= busy_nx;
    end
  end

  // R2: the selection moves only on the clock that closes a frame
  a_r2_sel_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wd_sel) |-> $past(frame_end));
  // R7: the selection is frozen while a write is busy
  a_r7_sel_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(wd_sel));
  // R7: busy window never exceeds its length
  a_r7_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= BW'(BUSY_CYCLES));
  // R8: the latch is clear when a busy period ends
  a_r8_wel_clear_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
endmodule

// File: rtl/wdc_so_path.sv
module wdc_so_path
  import wdc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               op_ready,
  input  logic [OP_BITS-1:0] op_byte,
  input  logic               sck_fall,
  input  logic               busy,
  input  logic [SEL_W-1:0]   wd_sel,
  output logic               so
);
  logic [OP_BITS-1:0] osh, osh_nx, rd_byte;
  logic               so_nx;

  always_comb begin
    rd_byte = '0;
    rd_byte[SEL_LSB +: SEL_W] = wd_sel;
    osh_nx = osh;
    so_nx  = so;
    if (frame_start) begin
      osh_nx = '0;
      so_nx  = 1'b0;
    end else if (op_ready && op_byte == OP_READ) begin
      osh_nx = busy ? '1 : rd_byte;
    end else if (sck_fall) begin
      so_nx  = osh[OP_BITS-1];
      osh_nx = {osh[OP_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osh <= '0;
      so  <= 1'b0;
    end else begin
      osh <= osh_nx;
      so  <= so_nx;
    end
  end

  // R6: SO moves only after an SCK fall or when a frame opens
  a_r6_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(so) |-> ($past(sck_fall) || $past(frame_start)));
endmodule

// File: rtl/wdc_spi_ctrl.sv
module wdc_spi_ctrl
  import wdc_pkg::*;
#(
  parameter int               BUSY_CYCLES = 2_000_000,
  parameter logic [SEL_W-1:0] SEL_RESET   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck,
  input  logic             si,
  output logic             so,
  output logic             so_oe,
  output logic [SEL_W-1:0] wd_sel
);
  logic [1:0]            rst_sync;
  logic                  rst_i;
  logic                  active, frame_start, frame_end, sck_fall, op_ready, busy;
  logic [OP_BITS-1:0]    op_byte;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  wdc_spi_rx u_rx (
    .clk(clk), .rst_n(rst_i), .cs_n(cs_n), .sck(sck), .si(si),
    .active(active), .frame_start(frame_start), .frame_end(frame_end),
    .sck_fall(sck_fall), .op_ready(op_ready), .op_byte(op_byte),
    .bit_cnt(bit_cnt), .word(word)
  );

  wdc_ctrl #(.BUSY_CYCLES(BUSY_CYCLES), .SEL_RESET(SEL_RESET)) u_ctrl (
    .clk(clk), .rst_n(rst_i), .frame_end(frame_end), .bit_cnt(bit_cnt),
    .word(word), .wd_sel(wd_sel), .busy(busy)
  );

  wdc_so_path u_so (
    .clk(clk), .rst_n(rst_i), .frame_start(frame_start), .op_ready(op_ready),
    .op_byte(op_byte), .sck_fall(sck_fall), .busy(busy), .wd_sel(wd_sel),
    .so(so)
  );

  assign so_oe = active & ~cs_n;

  // R10: output driver off whenever the target is deselected
  a_r10_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_i)
    $past(cs_n) && cs_n |-> !so_oe);
endmodule

// File: tb/wdc_spi_ctrl_bench.sv
module wdc_spi_ctrl_bench;
  localparam int BUSY = 600;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, sck, si;
  logic       so, so_oe;
  logic [1:0] wd_sel;

  int   checks = 0, fails = 0, cyc = 0;
  logic [1:0] exp_sel = 2'b00;
  logic m_wel = 1'b0, armed = 1'b0;
  int   busy_end = 0;

  always #2.5 clk = ~clk;

  wdc_spi_ctrl #(.BUSY_CYCLES(BUSY)) u_wdc_spi_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .so(so), .so_oe(so_oe), .wd_sel(wd_sel)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // cycle counter and watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "run-limit", cyc, 150000);
      finish_run();
    end
  end

  // per-clock comparison with the behavioural model (R1, R2, R10)
  always @(posedge clk) begin
    #1;
    chk(wd_sel === exp_sel, "R2 wd_sel vs model", wd_sel, exp_sel);
    chk(so_oe === (armed && !cs_n), "R10 so_oe vs model", so_oe, armed && !cs_n);
  end

  function automatic bit busy_now();
    return cyc < busy_end;
  endfunction

  // model of a frame closing with the given edge count and contents
  task automatic model_end(input int nbits, input logic [15:0] w);
    if (!busy_now()) begin
      if (nbits == 8 && w[15:8] == 8'h06) m_wel = 1'b1;
      if (nbits == 8 && w[15:8] == 8'h04) m_wel = 1'b0;
      if (nbits == 16 && w[15:8] == 8'h01 && m_wel && (w[7:0] & 8'hE7) == 8'h00) begin
        exp_sel  = w[4:3];
        m_wel    = 1'b0;
        busy_end = cyc + BUSY + 2;
      end
    end
  endtask

  task automatic xfer(input int nbits, input logic [15:0] w, output logic [7:0] rd);
    @(negedge clk);
    cs_n  = 1'b0;
    armed = 1'b1;
    rd    = 8'h00;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      si = (i < 16) ? w[15-i] : 1'b0;
      repeat (4) @(negedge clk);
      if (i >= 8 && i < 16) rd[15-i] = so;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    model_end(nbits, w);
    repeat (8) @(negedge clk);
  endtask

  task automatic op8(input logic [7:0] op);
    logic [7:0] d;
    xfer(8, {op, 8'h00}, d);
  endtask

  task automatic wr(input logic [7:0] data);
    logic [7:0] d;
    xfer(16, {8'h01, data}, d);
  endtask

  task automatic rd_chk(input string tag);
    logic [7:0] d, e;
    e = busy_now() ? 8'hFF : {3'b000, exp_sel, 3'b000};
    xfer(16, {8'h05, 8'h00}, d);
    chk(d === e, tag, d, e);
  endtask

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; si = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    chk(wd_sel === 2'b00, "R1 reset selection", wd_sel, 0);
    chk(so_oe === 1'b0, "R1 reset so_oe", so_oe, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R11: 06h clocked with cs_n low since reset is not taken
    for (int i = 0; i < 8; i++) begin
      si = (8'h06 >> (7 - i)) & 1'b1;
      repeat (4) @(negedge clk); sck = 1'b1;
      repeat (4) @(negedge clk); sck = 1'b0;
    end
    repeat (4) @(negedge clk); cs_n = 1'b1;
    repeat (8) @(negedge clk);
    wr(8'h18);
    chk(wd_sel === 2'b00, "R11 no arm before first select fall", wd_sel, 0);

    // R3: write with latch clear
    wr(8'h08);
    chk(wd_sel === 2'b00, "R3 write without latch", wd_sel, 0);

    // R2: arm and write 10b
    op8(8'h06);
    wr(8'h10);
    chk(wd_sel === 2'b10, "R2 accepted write", wd_sel, 2);

    // R7: busy read and ignored commands
    rd_chk("R7 busy read returns FFh");
    op8(8'h06);
    wr(8'h08);
    chk(wd_sel === 2'b10, "R7 write during busy ignored", wd_sel, 2);
    repeat (BUSY + 200) @(negedge clk);

    // R6: readback
    rd_chk("R6 readback 10h");

    // R8: latch cleared at completion
    wr(8'h08);
    chk(wd_sel === 2'b10, "R8 latch cleared after write", wd_sel, 2);

    // R4: disarm
    op8(8'h06);
    op8(8'h04);
    wr(8'h08);
    chk(wd_sel === 2'b10, "R4 disarm blocks write", wd_sel, 2);

    // R12: 06h with 9 edges does not arm
    xfer(9, {8'h06, 8'h00}, d);
    wr(8'h08);
    chk(wd_sel === 2'b10, "R12 arm needs exactly 8 edges", wd_sel, 2);

    // R5: wrong edge counts, latch kept
    op8(8'h06);
    xfer(15, {8'h01, 8'h08}, d);
    chk(wd_sel === 2'b10, "R5 15-edge write ignored", wd_sel, 2);
    xfer(17, {8'h01, 8'h08}, d);
    chk(wd_sel === 2'b10, "R5 17-edge write ignored", wd_sel, 2);
    wr(8'h18);
    chk(wd_sel === 2'b11, "R5 latch kept, 16-edge write taken", wd_sel, 3);
    repeat (BUSY + 200) @(negedge clk);
    rd_chk("R6 readback 18h");

    // R9: reserved bit set rejected, latch kept
    op8(8'h06);
    wr(8'h19);
    chk(wd_sel === 2'b11, "R9 reserved bit rejected", wd_sel, 3);
    rd_chk("R9 no busy after rejected write");
    wr(8'h00);
    chk(wd_sel === 2'b00, "R9 latch kept after rejection", wd_sel, 0);
    repeat (BUSY + 200) @(negedge clk);
    rd_chk("R6 readback 00h");

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule